// File: doc/BRIEF.md
# Paged-Address SPI Byte Bridge

This block gives a host control of an SPI flash device through a tiny register window. The window has five live offsets. Offsets 0 through 3 hold the bytes of a 32-bit target address, with offset 0 as the least significant byte. Offset 4 is a data port. Each data-port access is steered by the page (address bits 31:8) of the assembled address.

A data-port write to the release page drives chip select high. A data-port access to the data page drives chip select low and moves exactly one byte. A write sends the written byte. A read sends 0xFF and returns the byte received on MISO. There is no chip-select bit in any register: the host changes only address byte 1 to move between the two pages. A typical sequence is release, command bytes written, response bytes read, then release again.

Shifting uses SPI mode 0, MSB first, at the system clock divided by an even parameter. A data-page access is held off through `ready_o` until its byte has finished, so it is never lost.

Top module: `spi_page_bridge`

## Requirements
- R1: Offsets 0..3 store address bytes 0..3 little-endian, so the address is {byte3,byte2,byte1,byte0}. A read at offset 0..3 returns the stored byte. A register write changes only the byte it selects. Reset clears all four bytes to 0x00.
- R2: A data-port (offset 4) write of any value while address[31:8] equals 0xFFFFFE drives `cs_no` high, starting on the clock edge that accepts the access.
- R3: A data-port write while address[31:8] equals 0xFFFFFD drives `cs_no` low and sends the written byte on `mosi_o` MSB first, with eight `sclk_o` pulses. SCLK idles low, MOSI is stable while SCLK is high, and chip select is low for the whole byte.
- R4: A data-port read while address[31:8] equals 0xFFFFFD drives `cs_no` low, sends 0xFF, samples `miso_i` on each SCLK rising edge MSB first, and returns the received byte on `rdata_o` in the cycle where `ready_o` is high.
- R5: With divisor DIV, one SCLK period lasts DIV clock cycles. A data-page access sees `ready_o` low for exactly 8*DIV+1 samples: 1 in the request cycle plus 8*DIV while the byte moves. It then sees `ready_o` high for one cycle.
- R6: `busy_o` is high while a byte is moving, and `ready_o` stays low while `busy_o` is high. A request held through the stall completes afterwards and is not dropped. Every other access has `ready_o` high in its first cycle.
- R7: `cs_no` changes only on an accepted data-port access. It stays low across consecutive data-page accesses until a release-page write.
- R8: Data-port accesses at any other page, data-port reads at the release page, and accesses to offsets 5..7 cause no SCLK pulse and no chip-select change. Reads of these return 0xFF.
- R9: After reset `cs_no` is high, `sclk_o` is low, `busy_o` is low, and `ready_o` is low while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| off_i | input | 3 | Window offset |
| wdata_i | input | 8 | Host write data |
| ready_o | output | 1 | Access completes at the next clock edge |
| rdata_o | output | 8 | Read data, valid with ready_o |
| busy_o | output | 1 | A byte is being shifted |
| sclk_o | output | 1 | SPI clock, mode 0 |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |

## Verification
The bench runs random transactions against a device model that records MOSI on every rising SCLK edge and drives MISO with random bytes. Each transaction has a random number of command bytes and response bytes. Random byte values separate bit order and sampling-edge faults, and a wrong sampling edge gives a one-bit offset. The varied burst lengths show that chip select stays low between accesses and rises only on a release write.

Wait counts per access check the divider and the stall, and the SCLK pulse count per transaction finds missing or extra pulses. Random pages other than the two decoded pages, including a byte-swapped address, test the little-endian assembly and the no-effect rule. Release-page reads and offsets 5..7 are also tested to show they have no effect.

// File: rtl/spi_page_bridge_pkg.sv
package spi_page_bridge_pkg;
  localparam logic [2:0]  OFF_DATA     = 3'd4;
  localparam logic [23:0] PAGE_RELEASE = 24'hFFFFFE;
  localparam logic [23:0] PAGE_DATA    = 24'hFFFFFD;
  localparam logic [7:0]  IDLE_READ    = 8'hFF;

  typedef enum logic {ST_IDLE, ST_SHIFT} bridge_st_e;
endpackage

// File: rtl/spi_addr_window.sv
module spi_addr_window #(
  parameter int          NBYTES   = 4,
  parameter logic [23:0] REL_PAGE = 24'hFFFFFE,
  parameter logic [23:0] DAT_PAGE = 24'hFFFFFD
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(NBYTES)-1:0] sel_i,
  input  logic [7:0]               wdata_i,
  output logic [7:0]               byte_o,
  output logic                     hit_rel_o,
  output logic                     hit_dat_o
);
  localparam int AW = NBYTES * 8;

  logic [7:0] byte_q [NBYTES];
  logic [AW-1:0] addr;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           byte_q[g] <= '0;
      else if (we_i && sel_i == g[$clog2(NBYTES)-1:0]) byte_q[g] <= wdata_i;
    end
    assign addr[g*8 +: 8] = byte_q[g];

    // only the selected byte may change
    assert_byte_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && sel_i == g[$clog2(NBYTES)-1:0]) |=> $stable(byte_q[g]));
  end

  assign byte_o    = byte_q[sel_i];
  assign hit_rel_o = addr[AW-1:8] == REL_PAGE;
  assign hit_dat_o = addr[AW-1:8] == DAT_PAGE;
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic          busy_q, done_q, sclk_q;
  logic [7:0]    sr_q, rx_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      sr_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      bit_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        sr_q   <= tx_i;
        bit_q  <= '0;
        cnt_q  <= '0;
        sclk_q <= 1'b0;
      end else if (busy_q) begin
        if (cnt_q == CW'(HALF - 1)) begin
          cnt_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};   // sample on rising edge
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              sr_q  <= {sr_q[6:0], 1'b0};    // next bit on falling edge
            end
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = sr_q[7];

  assert_sclk_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sclk_q);
  assert_mosi_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_o));
  assert_done_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q && !sclk_q);
endmodule

// File: rtl/spi_page_bridge.sv
module spi_page_bridge
  import spi_page_bridge_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [2:0] off_i,
  input  logic [7:0] wdata_i,
  output logic       ready_o,
  output logic [7:0] rdata_o,
  output logic       busy_o,
  output logic       sclk_o,
  output logic       cs_no,
  output logic       mosi_o,
  input  logic       miso_i
);
  bridge_st_e state_q;
  logic       cs_q;
  logic       hit_rel, hit_dat, sh_busy, sh_done;
  logic [7:0] win_byte, sh_rx;
  logic       reg_acc, dp_acc, start, release_cs, reg_wr;

  assign reg_acc    = req_i && state_q == ST_IDLE && !off_i[2];
  assign dp_acc     = req_i && state_q == ST_IDLE && off_i == OFF_DATA;
  assign start      = dp_acc && hit_dat;
  assign release_cs = dp_acc && we_i && hit_rel;
  assign reg_wr     = reg_acc && we_i;

  spi_addr_window #(
    .NBYTES  (4),
    .REL_PAGE(PAGE_RELEASE),
    .DAT_PAGE(PAGE_DATA)
  ) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_wr),
    .sel_i    (off_i[1:0]),
    .wdata_i  (wdata_i),
    .byte_o   (win_byte),
    .hit_rel_o(hit_rel),
    .hit_dat_o(hit_dat)
  );

  spi_byte_shifter #(.DIV(DIV)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .tx_i   (we_i ? wdata_i : 8'hFF),
    .miso_i (miso_i),
    .busy_o (sh_busy),
    .done_o (sh_done),
    .rx_o   (sh_rx),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
    end else begin
      if (start)           cs_q <= 1'b0;
      else if (release_cs) cs_q <= 1'b1;
      case (state_q)
        ST_IDLE:  if (start)   state_q <= ST_SHIFT;
        ST_SHIFT: if (sh_done) state_q <= ST_IDLE;
        default:               state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ready_o = 1'b0;
    rdata_o = IDLE_READ;
    if (state_q == ST_SHIFT) begin
      ready_o = req_i && sh_done;
      rdata_o = sh_rx;
    end else begin
      ready_o = req_i && !start;
      if (!off_i[2]) rdata_o = win_byte;
    end
  end

  assign busy_o = sh_busy;
  assign cs_no  = cs_q;

  assert_cs_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dp_acc |=> $stable(cs_no));
  assert_cs_low_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cs_no);
  assert_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ready_o);
  assert_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_cs |=> cs_no);
endmodule

// File: tb/tb_spi_page_bridge.sv
module tb_spi_page_bridge;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [2:0] off = '0;
  logic [7:0] wdata = '0;
  logic       ready, busy, sclk, cs_n, mosi, miso;
  logic [7:0] rdata;

  always #5 clk = ~clk;

  spi_page_bridge #(.DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .off_i(off),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .busy_o(busy),
    .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  // device model
  logic [7:0] s_tx = 8'h00, s_sh = 8'h00, s_last = 8'h00;
  int         s_bit = 0, s_edges = 0;
  assign miso = s_tx[3'(7 - s_bit)];
  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) s_bit = 0;
    else begin
      s_sh = {s_sh[6:0], mosi};
      s_edges++;
      s_bit++;
      if (s_bit == 8) begin s_bit = 0; s_last = s_sh; end
    end
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [2:0] o, input logic [7:0] d,
                        output logic [7:0] rd, output int waits, output logic busy_mid);
    @(negedge clk);
    req = 1'b1; we = w; off = o; wdata = d;
    waits = 0; busy_mid = 1'b0;
    #1;
    while (!ready && waits < 1000) begin
      waits++;
      @(negedge clk); #1;
      if (waits == 2) busy_mid = busy;
    end
    rd = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wr(input logic [2:0] o, input logic [7:0] d);
    logic [7:0] rd; int w; logic b;
    access(1'b1, o, d, rd, w, b);
  endtask

  function automatic int exp_wait(input bit data_page);
    return data_page ? 8 * DIV + 1 : 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] rd, b1, pat;
    int w, e0;
    logic bm;
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    #1;
    chk(cs_n == 1'b1, "R9 cs", cs_n, 1);
    chk(sclk == 1'b0, "R9 sclk", sclk, 0);
    chk(busy == 1'b0, "R9 busy", busy, 0);
    chk(ready == 1'b0, "R9 ready", ready, 0);
    @(negedge clk); rst_ni = 1'b1;

    // R1: reset value and readback
    access(1'b0, 3'd2, 8'h00, rd, w, bm);
    chk(rd == 8'h00, "R1 reset byte", rd, 0);
    for (int i = 0; i < 4; i++) wr(3'(i), 8'(8'h11 * (i + 1)));
    for (int i = 0; i < 4; i++) begin
      access(1'b0, 3'(i), 8'h00, rd, w, bm);
      chk(rd == 8'(8'h11 * (i + 1)), "R1 readback", rd, 8'(8'h11 * (i + 1)));
      chk(w == 0, "R6 reg ready", w, 0);
    end

    // R1/R8: byte-swapped address does not hit the data page
    wr(3'd0, 8'hFD); wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    e0 = s_edges;
    access(1'b1, 3'd4, 8'hA5, rd, w, bm);
    chk(s_edges == e0 && cs_n, "R1 endian no hit", s_edges - e0, 0);

    // R8: offsets 5..7
    for (int o = 5; o < 8; o++) begin
      access(1'b0, 3'(o), 8'h00, rd, w, bm);
      chk(rd == 8'hFF, "R8 high offset read", rd, 8'hFF);
    end

    wr(3'd0, 8'h00);
    for (int t = 0; t < 40; t++) begin
      int nw, nr;
      nw = 1 + int'($urandom % 4);
      nr = 1 + int'($urandom % 4);
      wr(3'd1, 8'hFE);
      // R8: read at release page is inert
      access(1'b0, 3'd4, 8'h00, rd, w, bm);
      chk(rd == 8'hFF && w == 0, "R8 release read", rd, 8'hFF);
      wr(3'd4, 8'($urandom));
      chk(cs_n == 1'b1, "R2 release", cs_n, 1);
      e0 = s_edges;
      wr(3'd1, 8'hFD);
      for (int i = 0; i < nw; i++) begin
        pat = 8'($urandom);
        access(1'b1, 3'd4, pat, rd, w, bm);
        chk(s_last == pat, "R3 mosi byte", s_last, pat);
        chk(w == exp_wait(1), "R5 byte time", w, exp_wait(1));
        chk(bm == 1'b1, "R6 busy during shift", bm, 1);
        chk(cs_n == 1'b0, "R7 cs held", cs_n, 0);
      end
      for (int i = 0; i < nr; i++) begin
        s_tx = 8'($urandom);
        access(1'b0, 3'd4, 8'h00, rd, w, bm);
        chk(rd == s_tx, "R4 miso byte", rd, s_tx);
        chk(s_last == 8'hFF, "R4 fill byte", s_last, 8'hFF);
        chk(cs_n == 1'b0, "R7 cs held", cs_n, 0);
      end
      chk(s_edges - e0 == 8 * (nw + nr), "R3 pulse count", s_edges - e0, 8 * (nw + nr));
      // R8: unrelated page while cs low
      do b1 = 8'($urandom); while (b1 == 8'hFD || b1 == 8'hFE);
      wr(3'd1, b1);
      e0 = s_edges;
      access(t[0], 3'd4, 8'h3C, rd, w, bm);
      chk(s_edges == e0 && cs_n == 1'b0 && w == 0, "R8 other page", s_edges - e0, 0);
      if (!t[0]) chk(rd == 8'hFF, "R8 other page read", rd, 8'hFF);
      wr(3'd1, 8'hFE);
      wr(3'd4, 8'h00);
      chk(cs_n == 1'b1, "R2 final release", cs_n, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule